// File: doc/BRIEF.md
# Reciprocal Square Root Estimator (single precision)

This block produces a fast estimate of 1/sqrt(x) for one IEEE-754 single-precision operand per clock. It is meant to seed a Newton-Raphson refinement or to serve graphics-style normalisation, where about twelve correct bits are enough. Special operands (NaN, negative values, infinities, zeros and exactly 1.0) are recognised and answered with fixed encodings. A mode input selects whether denormal operands are flushed to signed zero before evaluation.

Every other operand is written as s·2^(2n). Here s lies in [1,2) when the unbiased exponent is even and in [2,4) when it is odd. The mantissa of s is evaluated on one of two piecewise-linear tables of 32 segments each, with a tangent line at each segment's midpoint. The result exponent is then lowered by n. The unit has three register stages and accepts a new operand every cycle.

Top module: `rsqrt_est`

## Requirements
- R1: When `dazMode` is 1, an operand whose exponent field is 0 is replaced by a zero carrying the operand's sign before any other rule applies. When `dazMode` is 0, such an operand is evaluated as a denormal.
- R2: An operand with exponent field 0xFF and a non-zero fraction returns the operand with fraction bit 22 set.
- R3: Any other operand with sign bit 1 that is not a zero returns 0xFFC00000. A negative zero returns 0xFF800000.
- R4: +infinity (0x7F800000) returns 0x00000000, and +0 returns 0x7F800000.
- R5: The operand 0x3F800000 (exactly 1.0) returns 0x3F800000.
- R6: For a finite positive normal operand other than 1.0, E = exponent field − 127. If E is even, the [1,2) table is used; if E is odd, the [2,4) table is used. The segment index is fraction bits 22:18. The offset from the midpoint is fraction bits 17:8 minus 512, a two's-complement value in [−512, 511]. Fraction bits 7:0 are ignored.
- R7: Let M = 65 + 2·index. The table words are the following floor square roots. [1,2) intercept: isqrt(floor(2^44/M)). [1,2) slope: isqrt(floor(2^38/M^3)). [2,4) intercept: isqrt(floor(2^43/M)). [2,4) slope: isqrt(floor(2^37/M^3)). The accumulator is 128·intercept − slope·offset, where 2^26 stands for 1.0.
- R8: If accumulator bit 26 is set, the result's unbiased exponent e is 0 and the kept fraction is bits 25:10. Otherwise, if bit 25 is set, e = −1 and the kept fraction is bits 24:9. Otherwise e = −2 and the kept fraction is bits 23:8. The result is sign 0, exponent field 127 + e − floor(E/2), the kept 16 bits in fraction bits 22:7, and zeros in bits 6:0.
- R9: A positive denormal with highest set fraction bit p is renormalised: E = −149 + p, and the fraction bits below the leading one are shifted up to the top. R6 to R8 then apply.
- R10: `outValid` rises exactly three clock edges after the edge that accepts an operand (`inValid` and `inReady` both 1), and one operand is accepted per cycle.
- R11: `inReady` and `outValid` are 0 during reset. `inReady` becomes 1 at the first edge with reset low and stays 1. An operand offered while `inReady` is 0 produces no result.
- R12: For every positive finite non-zero operand that is evaluated, the relative error of the result against 1/sqrt(x) is below 2^-12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand is offered this cycle |
| inReady | output | 1 | Unit accepts an operand this cycle |
| inData | input | 32 | Single-precision operand |
| dazMode | input | 1 | 1 flushes denormal operands to signed zero |
| outValid | output | 1 | `outData` holds a new result |
| outData | output | 32 | Single-precision estimate |

## Verification
On every cycle, the bound checker enforces several properties: the three-cycle link between acceptance and `outValid`, that ready stays up once raised, the fixed encodings for NaN, negative-normal and 1.0 operands, and the shape of evaluated results (positive sign, normal exponent, low seven fraction bits clear). The exact bit patterns that come out of the two tables and the exponent correction can only be shown by the bench's scenarios. Those scenarios also cover denormal renormalisation with the flush mode on and off, the segment edges near 1, 2 and 4, and the error bound. The bench compares each cycle against a behavioural model over directed and pseudo-random streams with gaps.

// File: rtl/rsqrt_pkg.sv
`timescale 1ns/1ps
package rsqrt_pkg;
  localparam int FP_W      = 32;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int BIAS      = 127;
  localparam int SEG_BITS  = 5;
  localparam int NSEG      = 1 << SEG_BITS;
  localparam int TRUNC_W   = 8;
  localparam int XFRAC_W   = FRAC_W - TRUNC_W;
  localparam int DELTA_W   = XFRAC_W - SEG_BITS;
  localparam int C_W       = 19;
  localparam int D_W       = 11;
  localparam int ICPT_SH   = 7;
  localparam int ACC_ONE   = C_W + ICPT_SH;
  localparam int ACC_W     = ACC_ONE + 4;
  localparam int KEEP_W    = 16;
  localparam int E_W       = EXP_W + 2;
  localparam int N_W       = EXP_W;
  localparam int LOG_FRAC  = $clog2(FRAC_W + 1);

  localparam logic [EXP_W-1:0] EXP_ALL1    = '1;
  localparam logic [FP_W-1:0]  QUIET_BIT   = 32'h0040_0000;
  localparam logic [FP_W-1:0]  DEFAULT_NAN = 32'hFFC0_0000;
  localparam logic [FP_W-1:0]  ONE_BITS    = 32'h3F80_0000;

  typedef struct packed {
    logic s1En;
    logic s2En;
    logic s3En;
  } stage_strobe_t;

  typedef struct packed {
    logic [C_W-1:0] icpt;
    logic [D_W-1:0] slope;
  } coef_t;

  function automatic logic [63:0] isqrtFloor(input logic [63:0] v);
    logic [63:0] res;
    logic [63:0] trial;
    res = '0;
    for (int b = 31; b >= 0; b--) begin
      trial = res | (64'd1 << b);
      if (trial * trial <= v) res = trial;
    end
    return res;
  endfunction

  function automatic logic [63:0] segMid(input int seg);
    return 64'((1 << (SEG_BITS + 1)) + 2 * seg + 1);
  endfunction

  function automatic logic [C_W-1:0] coefIcpt(input int seg, input bit hiRange);
    logic [63:0] num;
    num = hiRange ? (64'd1 << (2 * C_W + SEG_BITS)) : (64'd1 << (2 * C_W + SEG_BITS + 1));
    return C_W'(isqrtFloor(num / segMid(seg)));
  endfunction

  function automatic logic [D_W-1:0] coefSlope(input int seg, input bit hiRange);
    logic [63:0] num;
    logic [63:0] cube;
    cube = segMid(seg) * segMid(seg) * segMid(seg);
    num  = hiRange ? (64'd1 << (2 * D_W + 3 * SEG_BITS))
                   : (64'd1 << (2 * (D_W - 1) + 3 * (SEG_BITS + 1)));
    return D_W'(isqrtFloor(num / cube));
  endfunction
endpackage

// File: rtl/rsqrt_coef_rom.sv
`timescale 1ns/1ps
module rsqrt_coef_rom
  import rsqrt_pkg::*;
#(
  parameter int SEGS_LOG = SEG_BITS
) (
  input  logic [SEGS_LOG-1:0] seg,
  input  logic                hiRange,
  output coef_t               coef
);
  localparam int WORDS = 2 << SEGS_LOG;

  coef_t romArr [WORDS];

  // word address = {segment, range}: both ranges of one segment sit side by side
  for (genvar g = 0; g < WORDS; g++) begin : gen_word
    localparam coef_t WORD = '{icpt:  coefIcpt(g / 2, (g % 2) == 1),
                               slope: coefSlope(g / 2, (g % 2) == 1)};
    assign romArr[g] = WORD;
  end

  assign coef = romArr[{seg, hiRange}];
endmodule

// File: rtl/rsqrt_ctrl.sv
`timescale 1ns/1ps
module rsqrt_ctrl
  import rsqrt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output logic          inReady,
  output logic          outValid,
  output stage_strobe_t strobe
);
  logic v1Q;
  logic v2Q;
  logic v3Q;
  logic take;

  assign take = inValid && inReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      inReady <= 1'b0;
      v1Q     <= 1'b0;
      v2Q     <= 1'b0;
      v3Q     <= 1'b0;
    end else begin
      inReady <= 1'b1;
      v1Q     <= take;
      v2Q     <= v1Q;
      v3Q     <= v2Q;
    end
  end

  assign strobe.s1En = take;
  assign strobe.s2En = v1Q;
  assign strobe.s3En = v2Q;
  assign outValid    = v3Q;
endmodule

// File: rtl/rsqrt_dp.sv
`timescale 1ns/1ps
module rsqrt_dp
  import rsqrt_pkg::*;
(
  input  logic            clk,
  input  stage_strobe_t   strobe,
  input  logic            dazMode,
  input  logic [FP_W-1:0] inData,
  output logic [FP_W-1:0] outData
);
  // ---------------- stage 1: classify, flush, renormalise ----------------
  logic                     sgn;
  logic [EXP_W-1:0]         ex;
  logic [FRAC_W-1:0]        fr;
  logic [LOG_FRAC-1:0]      msb;
  logic [LOG_FRAC-1:0]      shAmt;
  logic [FRAC_W-1:0]        normFrac;
  logic signed [E_W-1:0]    unbE;
  logic signed [E_W-1:0]    halfE;
  logic                     specHit;
  logic [FP_W-1:0]          specVal;

  always_comb begin
    sgn = inData[FP_W-1];
    ex  = inData[FP_W-2 -: EXP_W];
    fr  = inData[FRAC_W-1:0];
    if (dazMode && ex == '0) fr = '0;
    msb = '0;
    for (int k = 0; k < FRAC_W; k++) begin
      if (fr[k]) msb = LOG_FRAC'(k);
    end
    shAmt    = LOG_FRAC'(FRAC_W) - msb;
    specHit  = 1'b1;
    specVal  = '0;
    normFrac = fr;
    unbE     = '0;
    if (ex == EXP_ALL1 && fr != '0) begin
      specVal = inData | QUIET_BIT;
    end else if (sgn && (ex != '0 || fr != '0)) begin
      specVal = DEFAULT_NAN;
    end else if (ex == EXP_ALL1) begin
      specVal = '0;
    end else if (ex == '0 && fr == '0) begin
      specVal = {sgn, EXP_ALL1, {FRAC_W{1'b0}}};
    end else if (inData == ONE_BITS) begin
      specVal = ONE_BITS;
    end else begin
      specHit = 1'b0;
      if (ex == '0) begin
        normFrac = fr << shAmt;
        unbE     = $signed(E_W'(msb)) - $signed(E_W'(BIAS - 1 + FRAC_W));
      end else begin
        unbE     = $signed(E_W'(ex)) - $signed(E_W'(BIAS));
      end
    end
    halfE = unbE >>> 1;
  end

  logic                     s1Spec;
  logic [FP_W-1:0]          s1SpecVal;
  logic                     s1Hi;
  logic [XFRAC_W-1:0]       s1XFrac;
  logic signed [N_W-1:0]    s1N;

  always_ff @(posedge clk) begin
    if (strobe.s1En) begin
      s1Spec    <= specHit;
      s1SpecVal <= specVal;
      s1Hi      <= unbE[0];
      s1XFrac   <= normFrac[FRAC_W-1 -: XFRAC_W];
      s1N       <= N_W'(halfE);
    end
  end

  // ---------------- stage 2: table lookup and linear evaluation ----------------
  coef_t                    coef;
  logic signed [DELTA_W-1:0] deltaS;
  logic signed [ACC_W-1:0]  icptExt;
  logic signed [ACC_W-1:0]  slopeExt;
  logic signed [ACC_W-1:0]  deltaExt;
  logic signed [ACC_W-1:0]  accNext;

  rsqrt_coef_rom #(.SEGS_LOG(SEG_BITS)) u_rom (
    .seg     (s1XFrac[XFRAC_W-1 -: SEG_BITS]),
    .hiRange (s1Hi),
    .coef    (coef)
  );

  // offset from segment midpoint: low bits minus half a segment
  assign deltaS   = $signed({~s1XFrac[DELTA_W-1], s1XFrac[DELTA_W-2:0]});
  assign icptExt  = $signed(ACC_W'({coef.icpt, {ICPT_SH{1'b0}}}));
  assign slopeExt = $signed(ACC_W'(coef.slope));
  assign deltaExt = ACC_W'(deltaS);
  assign accNext  = icptExt - slopeExt * deltaExt;

  logic                     s2Spec;
  logic [FP_W-1:0]          s2SpecVal;
  logic signed [N_W-1:0]    s2N;
  logic signed [ACC_W-1:0]  s2Acc;

  always_ff @(posedge clk) begin
    if (strobe.s2En) begin
      s2Spec    <= s1Spec;
      s2SpecVal <= s1SpecVal;
      s2N       <= s1N;
      s2Acc     <= accNext;
    end
  end

  // ---------------- stage 3: normalise, truncate, rescale ----------------
  logic signed [E_W-1:0]    eRes;
  logic [KEEP_W-1:0]        keepFrac;
  logic signed [E_W-1:0]    biasedExp;
  logic [FP_W-1:0]          coreRes;

  always_comb begin
    if (s2Acc[ACC_ONE]) begin
      eRes     = '0;
      keepFrac = s2Acc[ACC_ONE-1 -: KEEP_W];
    end else if (s2Acc[ACC_ONE-1]) begin
      eRes     = -E_W'(1);
      keepFrac = s2Acc[ACC_ONE-2 -: KEEP_W];
    end else begin
      eRes     = -E_W'(2);
      keepFrac = s2Acc[ACC_ONE-3 -: KEEP_W];
    end
    biasedExp = $signed(E_W'(BIAS)) + eRes - E_W'(s2N);
    coreRes   = {1'b0, biasedExp[EXP_W-1:0], keepFrac, {(FRAC_W-KEEP_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (strobe.s3En) begin
      outData <= s2Spec ? s2SpecVal : coreRes;
    end
  end
endmodule

// File: rtl/rsqrt_est.sv
`timescale 1ns/1ps
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic        dazMode,
  output logic        outValid,
  output logic [31:0] outData
);
  stage_strobe_t strobe;

  rsqrt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  rsqrt_dp u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .dazMode (dazMode),
    .inData  (inData),
    .outData (outData)
  );
endmodule

// File: rtl/rsqrt_est_chk.sv
`timescale 1ns/1ps
module rsqrt_est_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] inData,
  input logic        dazMode,
  input logic        outValid,
  input logic [31:0] outData
);
  logic accept;
  logic inNan;
  logic inNegNormal;
  logic inPosNormal;

  assign accept      = inValid && inReady;
  assign inNan       = (inData[30:23] == 8'hFF) && (inData[22:0] != '0);
  assign inNegNormal = inData[31] && (inData[30:23] != 8'h00) && (inData[30:23] != 8'hFF);
  assign inPosNormal = !inData[31] && (inData[30:23] != 8'h00) && (inData[30:23] != 8'hFF)
                       && (inData != 32'h3F80_0000);

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(accept, 3));

  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    inReady |=> inReady);

  // R2
  nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && $past(accept && inNan, 3) |-> outData == ($past(inData, 3) | 32'h0040_0000));

  // R3
  neg_default_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && $past(accept && inNegNormal, 3) |-> outData == 32'hFFC0_0000);

  // R5
  unity_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && $past(accept && inData == 32'h3F80_0000, 3) |-> outData == 32'h3F80_0000);

  // R8
  result_shape_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && $past(accept && inPosNormal, 3)
      |-> !outData[31] && outData[6:0] == '0 && outData[30:23] != 8'h00 && outData[30:23] != 8'hFF);
endmodule

bind rsqrt_est rsqrt_est_chk u_chk (.*);

// File: tb/tb_rsqrt_est.sv
`timescale 1ns/1ps
module tb_rsqrt_est;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        dazMode = 1'b0;
  logic        outValid;
  logic [31:0] outData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  rsqrt_est dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inData(inData), .dazMode(dazMode), .outValid(outValid), .outData(outData)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  function automatic longint bIsqrt(input longint n);
    longint x;
    longint y;
    if (n < 2) return n;
    x = n;
    y = (x + 1) / 2;
    while (y < x) begin
      x = y;
      y = (x + n / x) / 2;
    end
    return x;
  endfunction

  function automatic logic [31:0] refModel(input logic [31:0] v, input bit daz, output int cls);
    longint f, c, d, acc, m, frac, delta, xf, seg;
    int ex, e, hi, n, eR, p;
    bit s;
    s  = v[31];
    ex = int'(v[30:23]);
    f  = longint'(v[22:0]);
    cls = 0;
    if (daz && ex == 0 && f != 0) begin f = 0; cls = 1; end
    if (ex == 255 && f != 0) begin cls = 2; return v | 32'h0040_0000; end
    if (s && (ex != 0 || f != 0)) begin cls = 3; return 32'hFFC0_0000; end
    if (ex == 255) begin cls = 4; return 32'h0; end
    if (ex == 0 && f == 0) begin
      if (cls != 1) cls = 4;
      return {s, 8'hFF, 23'h0};
    end
    if (v == 32'h3F80_0000) begin cls = 5; return v; end
    if (ex == 0) begin
      p = 0;
      for (int k = 0; k < 23; k++) if (f[k]) p = k;
      e = -149 + p;
      f = (f << (23 - p)) & 64'h7F_FFFF;
      cls = 6;
    end else begin
      e = ex - 127;
      cls = 7;
    end
    hi    = e & 1;
    n     = (e - hi) / 2;
    xf    = f >> 8;
    seg   = xf >> 10;
    delta = (xf & 1023) - 512;
    m     = 65 + 2 * seg;
    c = hi ? bIsqrt((longint'(1) << 43) / m) : bIsqrt((longint'(1) << 44) / m);
    d = hi ? bIsqrt((longint'(1) << 37) / (m * m * m)) : bIsqrt((longint'(1) << 38) / (m * m * m));
    acc = c * 128 - d * delta;
    if (acc >= (longint'(1) << 26)) begin eR = 0;  frac = (acc >> 10) & 16'hFFFF; end
    else if (acc >= (longint'(1) << 25)) begin eR = -1; frac = (acc >> 9) & 16'hFFFF; end
    else begin eR = -2; frac = (acc >> 8) & 16'hFFFF; end
    return {1'b0, 8'(127 + eR - n), 16'(frac), 7'h0};
  endfunction

  function automatic string tagOf(input int cls);
    case (cls)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R9";
      default: return "R6/R7/R8";
    endcase
  endfunction

  function automatic real toReal(input logic [31:0] b);
    int ex;
    ex = int'(b[30:23]);
    if (ex == 0) return real'(b[22:0]) * (2.0 ** (-149));
    return (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (ex - 127));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h (time %0t)", tag, got, exp, $time);
    end
  endtask

  // ---------------- cycle model ----------------
  logic        expReady = 1'b0;
  logic        pV [3];
  logic [31:0] pD [3];
  logic [31:0] pI [3];
  int          pC [3];

  initial begin
    for (int k = 0; k < 3; k++) begin pV[k] = 1'b0; pD[k] = '0; pI[k] = '0; pC[k] = 0; end
  end

  always @(posedge clk) begin : model_step
    logic [31:0] e;
    int          c;
    e = refModel(inData, dazMode, c);
    if (rst) begin
      expReady <= 1'b0;
      for (int k = 0; k < 3; k++) pV[k] <= 1'b0;
    end else begin
      expReady <= 1'b1;
      pV[0] <= inValid && expReady;
      pD[0] <= e;
      pC[0] <= c;
      pI[0] <= inData;
      for (int k = 1; k < 3; k++) begin
        pV[k] <= pV[k-1];
        pD[k] <= pD[k-1];
        pC[k] <= pC[k-1];
        pI[k] <= pI[k-1];
      end
    end
  end

  always @(negedge clk) begin : compare_step
    real xr, er, rel;
    if (!done) begin
      if (rst) begin
        // reset state: R10 and R11
        check(outValid === 1'b0, "R10", {31'h0, outValid}, 32'h0);
        check(inReady === 1'b0, "R11", {31'h0, inReady}, 32'h0);
      end else begin
        check(inReady === expReady, "R11", {31'h0, inReady}, {31'h0, expReady});
        check(outValid === pV[2], "R10", {31'h0, outValid}, {31'h0, pV[2]});
        if (pV[2] && outValid === 1'b1) begin
          check(outData === pD[2], tagOf(pC[2]), outData, pD[2]);
          if (pC[2] == 6 || pC[2] == 7) begin
            xr  = toReal(pI[2]);
            er  = toReal(outData);
            rel = er * $sqrt(xr) - 1.0;
            if (rel < 0.0) rel = -rel;
            check(rel < 2.0 ** (-12), "R12", outData, pD[2]);
          end
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [31:0] v, input bit daz);
    @(negedge clk);
    inValid = 1'b1;
    inData  = v;
    dazMode = daz;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  logic [31:0] lfsr = 32'h1234_5678;

  task automatic stepLfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    // offered during reset and in the cycle ready is still low: ignored (R11)
    inValid = 1'b1;
    inData  = 32'h3FC0_0000;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle();
    // special classes (R2 R3 R4 R5)
    send(32'h7FC0_0000, 0); send(32'h7F80_0001, 0); send(32'hFF81_2345, 0);
    send(32'hBF80_0000, 0); send(32'hFF80_0000, 0); send(32'h8000_0001, 0);
    send(32'h8000_0000, 0); send(32'h0000_0000, 0); send(32'h7F80_0000, 0);
    send(32'h3F80_0000, 0);
    // both ranges, segment edges near 1, 2, 4 (R6 R7 R8)
    send(32'h3F80_0001, 0); send(32'h3FFF_FFFF, 0); send(32'h4000_0000, 0);
    send(32'h407F_FFFF, 0); send(32'h4080_0000, 0); send(32'h4040_0000, 0);
    send(32'h3FC0_0000, 0); send(32'h3E80_0000, 0); send(32'h42C8_0000, 0);
    send(32'h7F7F_FFFF, 0); send(32'h0080_0000, 0); send(32'h3F84_00FF, 0);
    idle();
    // denormals evaluated (R9) and flushed (R1)
    send(32'h0000_0001, 0); send(32'h007F_FFFF, 0); send(32'h0040_0000, 0);
    send(32'h0000_0001, 1); send(32'h807F_FFFF, 1); send(32'h0040_0000, 1);
    send(32'h3FC0_0000, 1); send(32'h8000_0001, 0);
    idle(); idle();
    // pseudo-random stream with gaps
    for (int t = 0; t < 3000; t++) begin
      stepLfsr();
      if (lfsr[1:0] == 2'b00) begin
        idle();
      end else begin
        send(lfsr[3:2] != 2'b00 ? {1'b0, lfsr[30:0]} : lfsr, lfsr[7:4] == 4'h0);
      end
    end
    idle();
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule